// File: doc/BRIEF.md
# Register and Flag Condition Evaluator

This block decides, for a single decoded instruction, whether a conditional control transfer, conditional trap or conditional move fires. It checks the instruction legality at the same time. The decoder supplies a form code and the fields it has already taken out of the instruction word. For branches and traps, the 4-bit flag condition comes from bits 28:25; for conditional moves, it comes from bits 17:14. The execute stage supplies a 64-bit source register value and both integer flag sets, one for 32-bit results and one for 64-bit results. The block returns three results: a taken decision, an illegal-instruction indication and a floating-point-disabled indication.

There are three kinds of test. The first compares the source register with zero as a signed 64-bit number, using a 3-bit register condition. The second applies a 4-bit flag condition to the flag set named by a 2-bit selector, which is used by branch and trap forms. The third applies a 4-bit flag condition to the flag set named by a 3-bit selector, which is used by conditional moves. In the 3-bit selector space, the lower half names floating-point flag sets. Those sets are not present here, so any value there raises floating-point-disabled.

Inputs are sampled on a cycle with `in_valid` high. The three results appear registered one clock later, together with `out_valid`.

Top module: `cond_eval_top`

## Requirements
- R1: With form 0 (register test), register condition 1 fires when the register is zero, 2 when it is zero or negative, and 3 when it is negative, all as signed 64-bit values.
- R2: With form 0, register condition 5 fires when the register is nonzero, 6 when it is strictly positive, and 7 when it is zero or positive (signed).
- R3: With form 0, register conditions 0 and 4 raise illegal and leave taken low.
- R4: The flag set is packed as bit3 N, bit2 Z, bit1 V, bit0 C. The flag conditions are: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. Codes 8 to 15 are the inverses of codes 0 to 7 in the same order, so 8 is always and 9 is !Z.
- R5: With form 1 (2-bit selector, cc_sel[1:0]), selector value 0 tests the 32-bit flag set and value 2 tests the 64-bit flag set.
- R6: With form 1, selector values 1 and 3 raise illegal.
- R7: With form 2 (3-bit selector, cc_sel[2:0]), selector values 0 to 3 raise floating-point-disabled.
- R8: With form 2, selector value 4 tests the 32-bit set and value 6 tests the 64-bit set; values 5 and 7 raise illegal.
- R9: Form 3 is reserved and raises illegal.
- R10: Taken is low whenever illegal or floating-point-disabled is high, and those two are never high together.
- R11: Results appear one clock after a cycle with in_valid high, marked by out_valid. out_valid is low on a cycle not preceded by in_valid. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs on this cycle are to be evaluated |
| form | input | 2 | 0 register test, 1 flag test with 2-bit selector, 2 flag test with 3-bit selector, 3 reserved |
| reg_val | input | 64 | Source register value |
| reg_cond | input | 3 | Register condition code |
| cc_sel | input | 3 | Flag-set selector bits {cc2, cc1, cc0} |
| flag_cond | input | 4 | Flag condition code |
| flags32 | input | 4 | 32-bit flag set {N,Z,V,C} |
| flags64 | input | 4 | 64-bit flag set {N,Z,V,C} |
| out_valid | output | 1 | Results valid |
| taken | output | 1 | Condition holds |
| illegal | output | 1 | Illegal-instruction indication |
| fp_off | output | 1 | Floating-point-disabled indication |

## Verification
Every register condition is applied to zero, one, minus one, the largest positive value and the most negative 64-bit value. This separates a signed comparison from an unsigned one, and separates a sign-bit test from a full zero test. Every flag condition is swept across all 16 flag patterns under every selector value. The 64-bit flag set is always driven with the complement of the 32-bit set, so a wrong set choice changes the answer. The reserved forms and selectors are covered in the same sweep. That shows illegal and floating-point-disabled override the taken decision whatever the flags say.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  typedef enum logic [1:0] {
    FORM_REG   = 2'd0,
    FORM_FLAG2 = 2'd1,
    FORM_FLAG3 = 2'd2,
    FORM_RSVD  = 2'd3
  } form_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/reg_zero_test.sv
module reg_zero_test #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val,
  input  logic [2:0]        code,
  output logic              hit,
  output logic              rsvd
);
  logic is_zero;
  logic is_neg;

  assign is_zero = ~|val;
  assign is_neg  = val[DATA_W-1];

  always_comb begin
    hit  = 1'b0;
    rsvd = 1'b0;
    unique case (code)
      3'd1:    hit = is_zero;
      3'd2:    hit = is_zero | is_neg;
      3'd3:    hit = is_neg;
      3'd5:    hit = ~is_zero;
      3'd6:    hit = ~is_zero & ~is_neg;
      3'd7:    hit = ~is_neg;
      default: rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_cond_test.sv
module flag_cond_test
  import cond_eval_pkg::*;
(
  input  flags_t     f,
  input  logic [3:0] cond,
  output logic       hit
);
  logic base;

  always_comb begin
    unique case (cond[2:0])
      3'd0: base = 1'b0;
      3'd1: base = f.z;
      3'd2: base = f.z | (f.n ^ f.v);
      3'd3: base = f.n ^ f.v;
      3'd4: base = f.c | f.z;
      3'd5: base = f.c;
      3'd6: base = f.n;
      default: base = f.v;
    endcase
  end

  assign hit = base ^ cond[3];
endmodule

// File: rtl/cc_bank_select.sv
module cc_bank_select
  import cond_eval_pkg::*;
(
  input  form_e      form,
  input  logic [2:0] sel,
  input  flags_t     f32,
  input  flags_t     f64,
  output flags_t     chosen,
  output logic       bad_sel,
  output logic       fp_bank
);
  logic use64;

  always_comb begin
    use64   = 1'b0;
    bad_sel = 1'b0;
    fp_bank = 1'b0;
    if (form == FORM_FLAG2) begin
      use64   = sel[1];
      bad_sel = sel[0];
    end else if (form == FORM_FLAG3) begin
      if (!sel[2]) fp_bank = 1'b1;
      else begin
        use64   = sel[1];
        bad_sel = sel[0];
      end
    end
  end

  assign chosen = use64 ? f64 : f32;
endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        form,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [2:0]        reg_cond,
  input  logic [2:0]        cc_sel,
  input  logic [3:0]        flag_cond,
  input  logic [FLAG_W-1:0] flags32,
  input  logic [FLAG_W-1:0] flags64,
  output logic              out_valid,
  output logic              taken,
  output logic              illegal,
  output logic              fp_off
);
  form_e  form_w;
  flags_t chosen;
  logic   reg_hit, reg_rsvd, flag_hit, bad_sel, fp_bank;
  logic   taken_d, illegal_d, fp_off_d;
  logic   taken_q, illegal_q, fp_off_q, valid_q;

  assign form_w = form_e'(form);

  reg_zero_test #(.DATA_W(DATA_W)) u_reg (
    .val(reg_val), .code(reg_cond), .hit(reg_hit), .rsvd(reg_rsvd)
  );

  cc_bank_select u_sel (
    .form(form_w), .sel(cc_sel), .f32(flags_t'(flags32)), .f64(flags_t'(flags64)),
    .chosen(chosen), .bad_sel(bad_sel), .fp_bank(fp_bank)
  );

  flag_cond_test u_flag (
    .f(chosen), .cond(flag_cond), .hit(flag_hit)
  );

  // next-state
  always_comb begin
    taken_d   = 1'b0;
    illegal_d = 1'b0;
    fp_off_d  = 1'b0;
    unique case (form_w)
      FORM_REG: begin
        illegal_d = reg_rsvd;
        taken_d   = reg_hit & ~reg_rsvd;
      end
      FORM_FLAG2, FORM_FLAG3: begin
        fp_off_d  = fp_bank;
        illegal_d = bad_sel & ~fp_bank;
        taken_d   = flag_hit & ~bad_sel & ~fp_bank;
      end
      default: illegal_d = 1'b1;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      taken_q   <= 1'b0;
      illegal_q <= 1'b0;
      fp_off_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        taken_q   <= taken_d;
        illegal_q <= illegal_d;
        fp_off_q  <= fp_off_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign taken     = taken_q;
  assign illegal   = illegal_q;
  assign fp_off    = fp_off_q;

  // R10
  taken_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_q || fp_off_q) |-> !taken_q);
  // R10
  fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_q, fp_off_q}));
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  rsvd_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 2'd0 && reg_cond[1:0] == 2'd0) |=> (illegal && !taken));
  // R7
  fp_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 2'd2 && !cc_sel[2]) |=> fp_off);
  // R9
  rsvd_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 2'd3) |=> illegal);
endmodule

// File: tb/sim_cond_eval_top.sv
module sim_cond_eval_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  form = '0;
  logic [63:0] reg_val = '0;
  logic [2:0]  reg_cond = '0;
  logic [2:0]  cc_sel = '0;
  logic [3:0]  flag_cond = '0;
  logic [3:0]  flags32 = '0;
  logic [3:0]  flags64 = '0;
  logic        out_valid, taken, illegal, fp_off;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  tk;
    logic  il;
    logic  fp;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  cond_eval_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
    .reg_val(reg_val), .reg_cond(reg_cond), .cc_sel(cc_sel),
    .flag_cond(flag_cond), .flags32(flags32), .flags64(flags64),
    .out_valid(out_valid), .taken(taken), .illegal(illegal), .fp_off(fp_off)
  );

  function automatic logic ref_flag(input logic [3:0] f, input logic [3:0] c);
    logic n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z || (n != v);
      4'd3:  return n != v;
      4'd4:  return cy || z;
      4'd5:  return cy;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z || (n != v));
      4'd11: return n == v;
      4'd12: return !(cy || z);
      4'd13: return !cy;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  function automatic exp_t ref_model(input logic [1:0] fm, input logic [63:0] rv,
                                     input logic [2:0] rc, input logic [2:0] cs,
                                     input logic [3:0] fc, input logic [3:0] f32,
                                     input logic [3:0] f64);
    exp_t e;
    longint s;
    e.tk = 0; e.il = 0; e.fp = 0;
    s = longint'(rv);
    if (fm == 2'd0) begin
      e.tag = (rc == 0 || rc == 4) ? "R3" : (rc < 4 ? "R1" : "R2");
      case (rc)
        3'd1: e.tk = (s == 0);
        3'd2: e.tk = (s <= 0);
        3'd3: e.tk = (s < 0);
        3'd5: e.tk = (s != 0);
        3'd6: e.tk = (s > 0);
        3'd7: e.tk = (s >= 0);
        default: e.il = 1;
      endcase
    end else if (fm == 2'd1) begin
      case (cs[1:0])
        2'd0: begin e.tk = ref_flag(f32, fc); e.tag = "R5/R4"; end
        2'd2: begin e.tk = ref_flag(f64, fc); e.tag = "R5/R4"; end
        default: begin e.il = 1; e.tag = "R6"; end
      endcase
    end else if (fm == 2'd2) begin
      if (cs < 4) begin e.fp = 1; e.tag = "R7"; end
      else if (cs == 4) begin e.tk = ref_flag(f32, fc); e.tag = "R8"; end
      else if (cs == 6) begin e.tk = ref_flag(f64, fc); e.tag = "R8"; end
      else begin e.il = 1; e.tag = "R8"; end
    end else begin
      e.il = 1; e.tag = "R9";
    end
    return e;
  endfunction

  task automatic drive(input logic [1:0] fm, input logic [63:0] rv, input logic [2:0] rc,
                       input logic [2:0] cs, input logic [3:0] fc, input logic [3:0] f32);
    @(negedge clk);
    in_valid = 1; form = fm; reg_val = rv; reg_cond = rc; cc_sel = cs;
    flag_cond = fc; flags32 = f32; flags64 = ~f32;
    exp_q.push_back(ref_model(fm, rv, rc, cs, fc, f32, ~f32));
  endtask

  // monitor (R11 timing: result one clock after drive)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: out_valid with nothing expected (actual 1, expected 0)");
      end else begin
        e = exp_q.pop_front();
        if ({taken, illegal, fp_off} !== {e.tk, e.il, e.fp}) begin
          n_fail++;
          $display("FAIL %s/R10: {taken,illegal,fp_off} actual %b%b%b expected %b%b%b",
                   e.tag, taken, illegal, fp_off, e.tk, e.il, e.fp);
        end
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] vals [6];
    vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = '1;
    vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[5] = 64'h0000_0001_0000_0000;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_checks++;
    if ({out_valid, taken, illegal, fp_off} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R11: reset outputs actual %b expected 0000",
               {out_valid, taken, illegal, fp_off});
    end
    rst_n = 1;
    // R1 R2 R3
    for (int rc = 0; rc < 8; rc++)
      for (int k = 0; k < 6; k++)
        drive(2'd0, vals[k], 3'(rc), 3'(k), 4'(rc), 4'(k));
    // R4 R5 R6
    for (int cs = 0; cs < 4; cs++)
      for (int fc = 0; fc < 16; fc++)
        for (int f = 0; f < 16; f++)
          drive(2'd1, 64'd0, 3'd1, 3'(cs), 4'(fc), 4'(f));
    // R7 R8
    for (int cs = 0; cs < 8; cs++)
      for (int fc = 0; fc < 16; fc++)
        for (int f = 0; f < 16; f++)
          drive(2'd2, 64'd0, 3'd1, 3'(cs), 4'(fc), 4'(f));
    // R9
    for (int k = 0; k < 4; k++)
      drive(2'd3, vals[k], 3'd1, 3'd0, 4'd8, 4'hF);
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    // R11 idle: no result without a request
    n_checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: idle out_valid actual %b expected 0, pending %0d",
               out_valid, exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule